// File: doc/BRIEF.md
# I2C Controller Start, Address and Write Sequencer

This block drives an I2C bus as the controller for the opening part of a write transaction. A start pulse makes it pull SDA low with SCL released. Once it sees its own start condition on the bus, it waits out the start hold time and then pulls SCL low. It then stays in a parked state until software loads a byte. Each loaded byte, whether the address-plus-write byte or a data byte, goes out MSB first as eight clocks. A ninth clock follows, during which SDA is released so the target can acknowledge.

The acknowledge level is captured when SCL is seen high on the ninth clock. An interrupt pulse marks the falling edge of that clock, for an ACK and for a NACK alike. After it, SCL stays low until the next byte is written, or until a stop is requested. The two lines are open drain: the outputs are pull-low enables, and the bus levels come back on the inputs through synchronisers.

The block follows clock stretching: a high phase is only timed from the moment SCL is actually observed high. All phase lengths are counted in system clock cycles. They are derived from the clock frequency parameter for standard and fast mode, and the mode is chosen at each start.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset both pull-low enables are 0 and the active, acknowledge and interrupt outputs are 0.
- R2: A start pulse while idle and inactive pulls SDA low while SCL stays released. The active output rises only after the synchronised bus shows SDA falling with SCL high, and at that point SCL is still high on the bus.
- R3: In standard mode, SCL is pulled low no earlier than ceil(4000 ns × CLK_KHZ / 1e6) cycles after SDA falls for the start.
- R4: Writing a byte while parked starts a transfer that presents the byte MSB first, one bit per SCL high phase, so a target sampling on SCL rising edges receives the written byte.
- R5: Every SCL low phase lasts at least ceil(4700 ns) of cycles and every high phase at least ceil(4000 ns) of cycles in standard mode (1300 ns and 600 ns in fast mode).
- R6: The controller releases SDA during the ninth clock of each byte, so the bus shows high there unless the target pulls it low.
- R7: The acknowledge output takes the value 1 when SDA is low, and 0 when SDA is high, at the observed rise of the ninth clock, and keeps that value until the next ninth clock.
- R8: The interrupt output is a single-cycle pulse raised as SCL is pulled low after the ninth clock, for both ACK and NACK.
- R9: After the interrupt, SCL stays pulled low for as long as no byte write and no stop request arrives.
- R10: When the target holds SCL low, the high-phase count starts only once SCL is seen high, so every high phase after stretching still meets the R5 minimum.
- R11: A stop request while parked pulls SDA low, releases SCL, and then releases SDA while SCL is high. The active output falls when that stop condition is seen on the bus, and both enables end at 0.
- R12: A start pulse while active and a byte write during a transfer are ignored: SCL stays pulled low, the SDA enable is unchanged, and the byte in flight is the one written first.
- R13: The mode input is sampled with the start pulse (1 = fast). In fast mode the start hold is ceil(600 ns) of cycles, so SCL falls well before the standard hold would expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Mode select sampled at start: 1 fast, 0 standard |
| start_i | input | 1 | Start trigger pulse |
| stop_i | input | 1 | Stop request pulse, honoured while parked |
| wr_valid_i | input | 1 | Byte write strobe into the shift register |
| wr_data_i | input | 8 | Byte to transmit (address plus write bit, or data) |
| scl_i | input | 1 | SCL level observed on the bus |
| sda_i | input | 1 | SDA level observed on the bus |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| active_o | output | 1 | Controller owns the bus (own start seen, no stop yet) |
| ack_o | output | 1 | Acknowledge detected on the last ninth clock |
| irq_o | output | 1 | One-cycle pulse at the end of each byte |

## Verification
The bench builds the block with CLK_KHZ set to 10000. That gives a 40-cycle standard hold and high phase, a 47-cycle low phase and a 6-cycle fast hold, so a full byte takes under a thousand cycles. With these values, standard and fast transactions, ACK and NACK bytes, stretching on chosen bits and stops all fit comfortably in one run. The minimum-phase measurements are made by a bench target model on the bus wires. They are compared against counts the bench computes from the same nanosecond limits.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_WAIT, ST_LOW, ST_RISE, ST_HIGH,
    ST_STOP_LOW, ST_STOP_RISE, ST_STOP_HIGH, ST_STOP_END
  } seq_state_e;

  // Cycles needed to cover ns at clk_khz, rounded up
  function automatic int unsigned ns_to_cyc(int unsigned clk_khz, int unsigned ns);
    longint unsigned p;
    p = longint'(clk_khz) * longint'(ns);
    return int'((p + 64'd999_999) / 64'd1_000_000);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= in_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], in_i};
    end
  endgenerate

  assign out_o = q[STAGES-1];
endmodule

// File: rtl/i2c_phase_timer.sv
`timescale 1ns/1ps
module i2c_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> val_i != '0); // R5
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o); // R5
endmodule

// File: rtl/i2c_byte_shift.sv
`timescale 1ns/1ps
module i2c_byte_shift #(
  parameter int unsigned W = 8,
  localparam int unsigned IDX_W = $clog2(W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     data_i,
  input  logic             shift_i,
  output logic             bit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [W-1:0]     sr_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= data_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o = sr_q[W-1];
  assign idx_o = idx_q;

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(W)); // R4
endmodule

// File: rtl/i2c_ctl_seq.sv
`timescale 1ns/1ps
module i2c_ctl_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 125000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              active_o,
  output logic              ack_o,
  output logic              irq_o
);
  localparam int unsigned HOLD_STD  = ns_to_cyc(CLK_KHZ, 4000);
  localparam int unsigned HOLD_FAST = ns_to_cyc(CLK_KHZ, 600);
  localparam int unsigned LOW_STD   = ns_to_cyc(CLK_KHZ, 4700);
  localparam int unsigned LOW_FAST  = ns_to_cyc(CLK_KHZ, 1300);
  localparam int unsigned HIGH_STD  = ns_to_cyc(CLK_KHZ, 4000);
  localparam int unsigned HIGH_FAST = ns_to_cyc(CLK_KHZ, 600);
  localparam int unsigned MAX_C     = (LOW_STD > HIGH_STD) ? LOW_STD : HIGH_STD;
  localparam int unsigned CNT_W     = $clog2(MAX_C + 1);
  localparam int unsigned IDX_W     = $clog2(BYTE_W + 1);

  seq_state_e state_q, state_d;
  logic fast_q, fast_d;
  logic ack_q, ack_d;
  logic irq_q, irq_d;
  logic hold_sda_q, hold_sda_d;
  logic active_q;

  logic scl_s, sda_s, sda_p_q;
  logic start_det, stop_det;

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] hold_c, low_c, high_c;

  logic             sh_load, sh_shift, sh_bit;
  logic [IDX_W-1:0] sh_idx;
  logic             ninth;

  i2c_line_sync #(.STAGES(2)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(scl_i), .out_o(scl_s));
  i2c_line_sync #(.STAGES(2)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(sda_i), .out_o(sda_s));

  i2c_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .done_o(tmr_done));

  i2c_byte_shift #(.W(BYTE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .data_i(wr_data_i),
    .shift_i(sh_shift), .bit_o(sh_bit), .idx_o(sh_idx));

  assign hold_c = fast_q ? CNT_W'(HOLD_FAST) : CNT_W'(HOLD_STD);
  assign low_c  = fast_q ? CNT_W'(LOW_FAST)  : CNT_W'(LOW_STD);
  assign high_c = fast_q ? CNT_W'(HIGH_FAST) : CNT_W'(HIGH_STD);
  assign ninth  = (sh_idx == IDX_W'(BYTE_W));

  // Bus condition detection on synchronised lines
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sda_p_q <= 1'b1;
    else         sda_p_q <= sda_s;

  assign start_det = scl_s &&  sda_p_q && !sda_s;
  assign stop_det  = scl_s && !sda_p_q &&  sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_q <= 1'b0;
    else if (start_det) active_q <= 1'b1;
    else if (stop_det)  active_q <= 1'b0;
  end

  always_comb begin
    state_d    = state_q;
    fast_d     = fast_q;
    ack_d      = ack_q;
    irq_d      = 1'b0;
    hold_sda_d = hold_sda_q;
    tmr_load   = 1'b0;
    tmr_val    = low_c;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && !active_q) begin
          fast_d  = fast_i;
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (start_det) begin
          tmr_load = 1'b1;
          tmr_val  = hold_c;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          hold_sda_d = 1'b1;
          state_d    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wr_valid_i) begin
          sh_load  = 1'b1;
          tmr_load = 1'b1;
          state_d  = ST_LOW;
        end else if (stop_i) begin
          tmr_load = 1'b1;
          state_d  = ST_STOP_LOW;
        end
      end
      ST_LOW: begin
        if (tmr_done) state_d = ST_RISE;
      end
      ST_RISE: begin
        // high phase timed only once SCL is really high (stretching)
        if (scl_s) begin
          tmr_load = 1'b1;
          tmr_val  = high_c;
          if (ninth) ack_d = !sda_s;
          state_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_done) begin
          if (ninth) begin
            irq_d      = 1'b1;
            hold_sda_d = 1'b0;
            state_d    = ST_WAIT;
          end else begin
            sh_shift = 1'b1;
            tmr_load = 1'b1;
            state_d  = ST_LOW;
          end
        end
      end
      ST_STOP_LOW: begin
        if (tmr_done) state_d = ST_STOP_RISE;
      end
      ST_STOP_RISE: begin
        if (scl_s) begin
          tmr_load = 1'b1;
          tmr_val  = high_c;
          state_d  = ST_STOP_HIGH;
        end
      end
      ST_STOP_HIGH: begin
        if (tmr_done) state_d = ST_STOP_END;
      end
      ST_STOP_END: begin
        hold_sda_d = 1'b0;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fast_q     <= 1'b0;
      ack_q      <= 1'b0;
      irq_q      <= 1'b0;
      hold_sda_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      fast_q     <= fast_d;
      ack_q      <= ack_d;
      irq_q      <= irq_d;
      hold_sda_q <= hold_sda_d;
    end
  end

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      ST_START, ST_HOLD: sda_oe_o = 1'b1;
      ST_WAIT: begin
        scl_oe_o = 1'b1;
        sda_oe_o = hold_sda_q;
      end
      ST_LOW: begin
        scl_oe_o = 1'b1;
        sda_oe_o = !ninth && !sh_bit;
      end
      ST_RISE, ST_HIGH: sda_oe_o = !ninth && !sh_bit;
      ST_STOP_LOW: begin
        scl_oe_o = 1'b1;
        sda_oe_o = 1'b1;
      end
      ST_STOP_RISE, ST_STOP_HIGH: sda_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign active_o = active_q;
  assign ack_o    = ack_q;
  assign irq_o    = irq_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8
  AST_IRQ_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> scl_oe_o); // R8
  AST_ACTIVE_OWN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(sda_oe_o)); // R2
  AST_WAIT_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !wr_valid_i && !stop_i) |=> scl_oe_o); // R9
  AST_STRETCH_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RISE && !scl_s) |=> state_q == ST_RISE); // R10
  AST_ACK_SDA_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ninth && state_q == ST_HIGH) |-> !sda_oe_o); // R6
endmodule

// File: tb/i2c_ctl_seq_test.sv
`timescale 1ns/1ps
module i2c_ctl_seq_test;
  localparam int unsigned KHZ = 10000;
  localparam int HOLD_S = (KHZ * 4000 + 999_999) / 1_000_000;
  localparam int HOLD_F = (KHZ * 600  + 999_999) / 1_000_000;
  localparam int LOW_S  = (KHZ * 4700 + 999_999) / 1_000_000;
  localparam int LOW_F  = (KHZ * 1300 + 999_999) / 1_000_000;
  localparam int HIGH_S = (KHZ * 4000 + 999_999) / 1_000_000;
  localparam int HIGH_F = (KHZ * 600  + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast = 1'b0, start = 1'b0, stop = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic scl_oe, sda_oe, active, ack, irq;
  logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
  wire  scl_bus = !(scl_oe || tgt_scl_low);
  wire  sda_bus = !(sda_oe || tgt_sda_low);

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  i2c_ctl_seq #(.CLK_KHZ(KHZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fast_i(fast), .start_i(start), .stop_i(stop),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .active_o(active), .ack_o(ack),
    .irq_o(irq));

  // Target model and bus monitor, sampled on the falling clock edge
  int cyc = 0, bits = 0, hi_run = 0, lo_run = 0, min_hi = 0, min_lo = 0;
  int start_cyc = 0, fall_cyc = 0, starts = 0, stops = 0, irq_hi = 0;
  int st_at = 0, st_len = 0, st_cnt = 0;
  logic ack_en = 1'b0, ninth_sda = 1'b0;
  logic [7:0] rx = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_hi++;
    if (scl_bus && scl_p && !sda_bus && sda_p) begin
      start_cyc = cyc; bits = 0; starts++;
    end
    if (scl_bus && scl_p && sda_bus && !sda_p) stops++;
    if (scl_bus && !scl_p) begin
      if (lo_run < min_lo) min_lo = lo_run;
      hi_run = 1;
      if (bits < 8) rx = {rx[6:0], sda_bus};
      else ninth_sda = sda_bus;
      bits++;
    end else if (scl_bus) hi_run++;
    if (!scl_bus && scl_p) begin
      if (hi_run < min_hi) min_hi = hi_run;
      lo_run = 1;
      fall_cyc = cyc;
      if (bits == 8) tgt_sda_low = ack_en;
      else if (bits == 9) begin tgt_sda_low = 1'b0; bits = 0; end
      if (st_len > 0 && bits == st_at) begin tgt_scl_low = 1'b1; st_cnt = st_len; end
    end else if (!scl_bus) lo_run++;
    if (tgt_scl_low) begin
      st_cnt--;
      if (st_cnt <= 0) tgt_scl_low = 1'b0;
    end
    scl_p = scl_bus;
    sda_p = sda_bus;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 enables", {scl_oe, sda_oe}, 0);
    chk(!active && !ack && !irq, "R1 flags", {active, ack, irq}, 0);
  endtask

  task automatic t_start(input logic f);
    int g, hold;
    fast = f;
    pulse_start();
    g = 0;
    while (!active && g < 5000) begin @(negedge clk); g++; end
    chk(active && !sda_bus && scl_bus, "R2 active with own start, SCL high",
        {active, sda_bus, scl_bus}, 3'b101);
    g = 0;
    while (scl_bus && g < 5000) begin @(negedge clk); g++; end
    @(negedge clk);
    hold = fall_cyc - start_cyc;
    if (!f) chk(hold >= HOLD_S, "R3 std start hold", hold, HOLD_S);
    else begin
      chk(hold >= HOLD_F, "R13 fast start hold min", hold, HOLD_F);
      chk(hold < HOLD_S, "R13 fast start hold below std", hold, HOLD_S);
    end
  endtask

  task automatic t_byte(input logic [7:0] d, input logic a, input int sat,
                        input int slen, input bit dup, input logic f);
    int g;
    ack_en = a; st_at = sat; st_len = slen;
    min_hi = 1 << 20; min_lo = 1 << 20; irq_hi = 0;
    @(posedge clk); #1 wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
    if (dup) begin
      step(100);
      wr_valid = 1'b1; wr_data = ~d;
      step(1);
      wr_valid = 1'b0;
    end
    g = 0;
    while (irq_hi == 0 && g < 20000) begin @(negedge clk); g++; end
    step(3);
    @(negedge clk);
    chk(rx == d, dup ? "R12 write during transfer ignored" : "R4 byte on bus",
        rx, d);
    chk(ack == a, "R7 ack flag", ack, a);
    chk(ninth_sda == !a, "R6 SDA free on ninth clock", ninth_sda, !a);
    chk(irq_hi == 1, "R8 irq single pulse", irq_hi, 1);
    chk(min_hi >= (f ? HIGH_F : HIGH_S), slen > 0 ? "R10 high after stretch" : "R5 high phase",
        min_hi, f ? HIGH_F : HIGH_S);
    chk(min_lo >= (f ? LOW_F : LOW_S), "R5 low phase", min_lo, f ? LOW_F : LOW_S);
    st_len = 0;
    step(100);
    @(negedge clk);
    chk(!scl_bus && scl_oe, "R9 SCL held after irq", scl_bus, 0);
  endtask

  task automatic t_ignore_start();
    logic s0;
    int st0;
    @(negedge clk);
    s0 = sda_oe; st0 = starts;
    pulse_start();
    step(20);
    @(negedge clk);
    chk(scl_oe && sda_oe == s0 && starts == st0, "R12 start while active ignored",
        {scl_oe, sda_oe}, {1'b1, s0});
  endtask

  task automatic t_stop();
    int g, sp0;
    sp0 = stops;
    @(posedge clk); #1 stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
    g = 0;
    while (active && g < 5000) begin @(negedge clk); g++; end
    step(2);
    @(negedge clk);
    chk(!active && stops == sp0 + 1, "R11 stop seen, inactive", {active, stops - sp0}, 1);
    chk(!scl_oe && !sda_oe && scl_bus && sda_bus, "R11 lines released",
        {scl_oe, sda_oe}, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_start(1'b0);
    t_byte(8'hA4, 1'b1, 0, 0, 1'b0, 1'b0);
    t_ignore_start();
    t_byte(8'h3C, 1'b0, 3, 60, 1'b1, 1'b0);
    t_stop();
    step(50);
    t_start(1'b1);
    t_byte(8'h5B, 1'b1, 5, 30, 1'b0, 1'b1);
    t_byte(8'hFF, 1'b0, 0, 0, 1'b0, 1'b1);
    t_byte(8'h00, 1'b1, 8, 25, 1'b0, 1'b1);
    t_stop();
    summary();
    $finish;
  end
endmodule